// File: doc/BRIEF.md
# Strap-addressed I2C target with identity query

This block is the serial front end of a small register bank. It watches an I2C clock and data pair, which it samples with the system clock, and it pulls the data line low through an open-drain enable when it acknowledges or sends a zero. Its 7-bit bus address has a fixed upper nibble of 1000. The lower three bits come from two three-level strap inputs, which arrive already resolved into low, high or floating codes. One strap combination gives no address, and the block then stays silent on the bus.

A controller writes a register pointer and then data bytes, which leave the block as one-cycle write strobes on an address/data port. It reads bytes back from the current pointer. The block also answers the reserved identity query. The controller sends the reserved byte 1111_1000, then a byte naming this target, then a repeated START and 1111_1001. The block then returns a fixed 24-bit identifier as three bytes. Stray bus events cancel a pending query, as the requirements below state.

Top module: `i2c_id_target`

## Requirements
- R1: Strap codes are 2'b00 low, 2'b01 high, and 2'b10 or 2'b11 floating. With the pair written (strap_a1, strap_a0), the low address bits are 0Z=0, 01=1, Z0=2, ZZ=3, Z1=4, 10=5, 1Z=6 and 11=7. The bus address is {1000, low bits}. The target acknowledges an address byte (address in bits 7:1, read/write in bit 0) that carries its own address, and acknowledges no other target address.
- R2: With both straps low, the target acknowledges no byte, including the reserved byte 1111_1000, and issues no write strobe.
- R3: In a write, the byte after the address sets the register pointer. Each following data byte is acknowledged and produces a one-cycle reg_we pulse with reg_addr equal to the pointer. The pointer then increments by one.
- R4: In a read (address bit 0 = 1), each byte sent MSB first is reg_rdata at the current pointer, and the pointer then increments. The target leaves SDA released during the controller's acknowledge slot.
- R5: After START, the target acknowledges the byte 1111_1000. It acknowledges the byte that follows only if bits 7:1 equal its own address, whatever bit 0 holds.
- R6: After an acknowledged query byte, a repeated START and 1111_1001, the target returns {MFR[11:0], PART[8:0], REV[2:0]} MSB first in three bytes. After the third byte it releases the bus even if the controller acknowledges.
- R7: A STOP after the query byte cancels the query, so that a later START with 1111_1001 gets no acknowledge.
- R8: An address byte other than 1111_1001 after a repeated START cancels a pending query.
- R9: A controller NACK on any identifier byte ends the sequence. The target releases SDA, and a further 1111_1001 is not acknowledged.
- R10: Transfers work at both 100 kbit/s and 400 kbit/s with a 125 MHz system clock.
- R11: Out of reset, sda_oe and reg_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| strap_a1 | input | 2 | Upper strap code (00 low, 01 high, 1x floating) |
| strap_a0 | input | 2 | Lower strap code (00 low, 01 high, 1x floating) |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at reg_addr |

## Verification
The hardest cases to reach are the cancellation rules of the identity query. Each needs a full armed state: the reserved byte and a matching target byte must be acknowledged, and then a STOP, a foreign address, or a controller NACK must arrive before 1111_1001. The bench builds each of these sequences with its own bus tasks. It then sends 1111_1001 and checks that no acknowledge comes back. It also clocks a byte after a NACK and checks that it reads as all ones. The address table is swept over every strap pair against all eight candidate low addresses.

// File: rtl/i2c_id_target.sv
module i2c_id_target #(
  parameter logic [3:0]  BASE    = 4'b1000,
  parameter logic [11:0] ID_MFR  = 12'hA3C,
  parameter logic [8:0]  ID_PART = 9'h15B,
  parameter logic [2:0]  ID_REV  = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap_a1,
  input  logic [1:0] strap_a0,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam logic [7:0]  QRY_W   = 8'hF8;
  localparam logic [7:0]  QRY_R   = 8'hF9;
  localparam logic [23:0] ID_WORD = {ID_MFR, ID_PART, ID_REV};

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} state_t;
  typedef enum logic [2:0] {P_ADDR, P_IDSEL, P_PTR, P_DATA, P_HOLD, P_TXN, P_TXID} phase_t;

  logic [2:0] scl_p, sda_p;
  state_t     state;
  phase_t     phase, d_ph;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr, nb;
  logic [1:0] idx;
  logic       armed, mack;
  logic       d_ack, d_set, d_clr, d_wr, d_ptr;
  logic [1:0] t1, t0;
  logic [2:0] lo;
  logic       addr_ok;
  logic [6:0] my_addr;

  wire sda_s    = sda_p[1];
  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire scl_hi   = scl_p[1] & scl_p[2];
  wire start    = scl_hi & sda_p[2] & ~sda_p[1];
  wire stop     = scl_hi & ~sda_p[2] & sda_p[1];
  wire id_done  = (phase == P_TXID) && (idx == 2'd3);

  assign reg_addr = ptr;

  assign t1 = (strap_a1 == 2'b00) ? 2'd0 : (strap_a1 == 2'b01) ? 2'd1 : 2'd2;
  assign t0 = (strap_a0 == 2'b00) ? 2'd0 : (strap_a0 == 2'b01) ? 2'd1 : 2'd2;
  assign my_addr = {BASE, lo};

  always_comb begin
    lo = 3'd0;
    addr_ok = 1'b1;
    case ({t1, t0})
      4'b0010: lo = 3'd0;
      4'b0001: lo = 3'd1;
      4'b1000: lo = 3'd2;
      4'b1010: lo = 3'd3;
      4'b1001: lo = 3'd4;
      4'b0100: lo = 3'd5;
      4'b0110: lo = 3'd6;
      4'b0101: lo = 3'd7;
      default: addr_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (idx)
      2'd0:    nb = ID_WORD[23:16];
      2'd1:    nb = ID_WORD[15:8];
      default: nb = ID_WORD[7:0];
    endcase
    if (phase != P_TXID) nb = reg_rdata;
  end

  always_comb begin
    d_ack = 1'b0; d_ph = P_HOLD; d_set = 1'b0; d_clr = 1'b0; d_wr = 1'b0; d_ptr = 1'b0;
    case (phase)
      P_ADDR: begin
        d_clr = 1'b1;
        if (addr_ok && sh[7:1] == my_addr) begin
          d_ack = 1'b1;
          d_ph  = sh[0] ? P_TXN : P_PTR;
        end else if (addr_ok && sh == QRY_W) begin
          d_ack = 1'b1;
          d_ph  = P_IDSEL;
        end else if (armed && sh == QRY_R) begin
          d_ack = 1'b1;
          d_ph  = P_TXID;
          d_clr = 1'b0;
        end
      end
      P_IDSEL: begin
        if (addr_ok && sh[7:1] == my_addr) begin
          d_ack = 1'b1;
          d_set = 1'b1;
        end else begin
          d_clr = 1'b1;
        end
      end
      P_PTR: begin
        d_ack = 1'b1; d_ptr = 1'b1; d_ph = P_DATA;
      end
      P_DATA: begin
        d_ack = 1'b1; d_wr = 1'b1; d_ph = P_DATA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= P_ADDR; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; idx <= '0; armed <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; reg_we <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 8'd1;
      if (start) begin
        state <= S_RX; phase <= P_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE; sda_oe <= 1'b0; armed <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (d_set) armed <= 1'b1;
              if (d_clr) armed <= 1'b0;
              if (d_ptr) ptr <= sh;
              if (d_wr) begin
                reg_we    <= 1'b1;
                reg_wdata <= sh;
              end
              if (d_ph == P_TXID) idx <= 2'd0;
              phase <= d_ph;
              if (d_ack) begin
                sda_oe <= 1'b1;
                state  <= S_RACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (phase == P_TXN || phase == P_TXID) begin
                state  <= S_TX;
                sda_oe <= ~nb[7];
                tx     <= {nb[6:0], 1'b0};
                cnt    <= 4'd1;
                if (phase == P_TXID) idx <= idx + 2'd1;
                else ptr <= ptr + 8'd1;
              end else begin
                state <= S_RX;
                cnt   <= '0;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_TACK;
              end else begin
                sda_oe <= ~tx[7];
                tx     <= {tx[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack && !id_done) begin
                state  <= S_TX;
                sda_oe <= ~nb[7];
                tx     <= {nb[6:0], 1'b0};
                cnt    <= 4'd1;
                if (phase == P_TXID) idx <= idx + 2'd1;
                else ptr <= ptr + 8'd1;
              end else begin
                state <= S_IDLE;
                if (phase == P_TXID) armed <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 8'd1));
  a_r2_silent_unstrapped: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (!sda_oe && !reg_we));
  a_r4_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && !$past(start) && !$past(stop)) |-> $stable(sda_oe));
  a_r7_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !armed);
  a_r9_nack_ends_query: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TACK && scl_fall && !mack && phase == P_TXID) |=> (!armed && !sda_oe && state == S_IDLE));
endmodule

// File: tb/i2c_id_target_bench.sv
`timescale 1ns/1ps
module i2c_id_target_bench;
  localparam logic [11:0] MFR  = 12'hA3C;
  localparam logic [8:0]  PART = 9'h15B;
  localparam logic [2:0]  REV  = 3'd5;
  localparam logic [23:0] IDW  = {MFR, PART, REV};
  localparam logic [31:0] SEQ  = {4'b0101, 4'b0110, 4'b0100, 4'b1001,
                                  4'b1010, 4'b1000, 4'b0001, 4'b0010};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap_a1 = 2'b10, strap_a0 = 2'b01;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [16];
  int we_cnt = 0, errs = 0, checks = 0, q = 10;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr[3:0]];

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr[3:0]] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  i2c_id_target #(.ID_MFR(MFR), .ID_PART(PART), .ID_REV(REV)) u_i2c_id_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap_a1(strap_a1), .strap_a0(strap_a0), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic rd(input logic ack_it, output logic [7:0] b, output logic rel);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); m_scl = 1'b0;
    end
    wq(); m_sda = ~ack_it; wq(); m_scl = 1'b1; wq(); rel = ~sda_oe; wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic exp_lo(input int c1, input int c0, output logic v, output logic [2:0] lo);
    v = 1'b0; lo = 3'd0;
    for (int i = 0; i < 8; i++)
      if (SEQ[4*i +: 4] == {c1[1:0], c0[1:0]}) begin v = 1'b1; lo = i[2:0]; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic ack, rel, v;
    logic [2:0] lo;
    logic [7:0] b;
    int base_we;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 7 + 1);
    repeat (5) @(negedge clk);
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R2: sweep all strap pairs against all low addresses
    for (int c1 = 0; c1 < 3; c1++)
      for (int c0 = 0; c0 < 3; c0++) begin
        strap_a1 = c1[1:0]; strap_a0 = c0[1:0];
        exp_lo(c1, c0, v, lo);
        for (int a = 0; a < 8; a++) begin
          bstart(); wr({4'b1000, a[2:0], 1'b0}, ack); bstop();
          chk(v ? "R1 address ack" : "R2 unstrapped ack", ack, v && (a[2:0] == lo));
        end
      end
    strap_a1 = 2'b11; strap_a0 = 2'b11;
    bstart(); wr(8'h86, ack); bstop();
    chk("R1 code 11 floating", ack, 1);

    strap_a1 = 2'b00; strap_a0 = 2'b00;
    base_we = we_cnt;
    bstart(); wr(8'h80, ack); wr(8'h02, ack); wr(8'h77, ack); bstop();
    bstart(); wr(8'hF8, ack); bstop();
    chk("R2 reserved byte ignored", ack, 0);
    chk("R2 no write strobe", we_cnt - base_we, 0);
    chk("R2 memory untouched", mem[2], 8'd15);

    strap_a1 = 2'b10; strap_a0 = 2'b01; // address 0x44
    // R3 write burst
    base_we = we_cnt;
    bstart(); wr(8'h88, ack); wr(8'h03, ack); wr(8'hAA, ack); wr(8'h55, ack); wr(8'hC3, ack); bstop();
    chk("R3 last data ack", ack, 1);
    chk("R3 strobe count", we_cnt - base_we, 3);
    chk("R3 mem3", mem[3], 8'hAA);
    chk("R3 mem4", mem[4], 8'h55);
    chk("R3 mem5", mem[5], 8'hC3);
    chk("R3 mem6 untouched", mem[6], 8'd43);

    // R4 read burst from pointer
    bstart(); wr(8'h88, ack); wr(8'h03, ack); bstart(); wr(8'h89, ack);
    chk("R4 read address ack", ack, 1);
    rd(1'b1, b, rel); chk("R4 byte0", b, 8'hAA); chk("R4 ack slot released", rel, 1);
    rd(1'b1, b, rel); chk("R4 byte1", b, 8'h55);
    rd(1'b0, b, rel); chk("R4 byte2", b, 8'hC3); chk("R4 nack slot released", rel, 1);
    bstop();

    // R5 / R6 identity query
    bstart(); wr(8'hF8, ack); chk("R5 reserved ack", ack, 1);
    wr(8'h89, ack); chk("R5 own address lsb ignored", ack, 1);
    bstart(); wr(8'hF9, ack); chk("R6 query read ack", ack, 1);
    rd(1'b1, b, rel); chk("R6 id byte0", b, IDW[23:16]);
    rd(1'b1, b, rel); chk("R6 id byte1", b, IDW[15:8]);
    rd(1'b1, b, rel); chk("R6 id byte2", b, IDW[7:0]);
    rd(1'b0, b, rel); chk("R6 released after third", b, 8'hFF);
    bstop();

    bstart(); wr(8'hF8, ack); wr(8'h8A, ack); chk("R5 other target no ack", ack, 0);
    bstart(); wr(8'hF9, ack); chk("R5 query after mismatch", ack, 0);
    bstop();

    // R7 stop cancels
    bstart(); wr(8'hF8, ack); wr(8'h88, ack); chk("R7 armed", ack, 1);
    bstop(); bstart(); wr(8'hF9, ack); chk("R7 query after stop", ack, 0);
    bstop();

    // R8 foreign address cancels
    bstart(); wr(8'hF8, ack); wr(8'h88, ack);
    bstart(); wr(8'h94, ack); chk("R8 foreign address", ack, 0);
    bstart(); wr(8'hF9, ack); chk("R8 query after foreign", ack, 0);
    bstop();

    // R9 nack ends query
    bstart(); wr(8'hF8, ack); wr(8'h88, ack);
    bstart(); wr(8'hF9, ack);
    rd(1'b0, b, rel); chk("R9 id byte0", b, IDW[23:16]);
    rd(1'b0, b, rel); chk("R9 bus released", b, 8'hFF);
    bstart(); wr(8'hF9, ack); chk("R9 query after nack", ack, 0);
    bstop();

    // R10 fast rate
    q = 78;
    bstart(); wr(8'h88, ack); wr(8'h0C, ack); wr(8'hE1, ack); wr(8'h1E, ack);
    bstart(); wr(8'h89, ack); rd(1'b0, b, rel); bstop();
    chk("R10 fast write", mem[13], 8'h1E);
    chk("R10 fast read", b, 8'd99);
    // R10 standard rate
    q = 312;
    bstart(); wr(8'h88, ack); wr(8'h09, ack); wr(8'h5A, ack);
    bstart(); wr(8'h89, ack); rd(1'b0, b, rel); bstop();
    chk("R10 standard write", mem[9], 8'h5A);
    chk("R10 standard read", b, 8'd71);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule